// File: doc/BRIEF.md
# Pseudo-Static RAM Host Controller

This block sits between a simple request/ready bus master and a 64K x 8 pseudo-static RAM. A request on the host side is a read, a write or a read-modify-write. The block turns each request into the memory's strobe sequence: chip-enable pair, read/write strobe, output enable and refresh pin, with a 16-bit address register and a split 8-bit data bus (out, drive-enable, in). The bus can be joined into one tri-state pad outside the block. All timing is counted in clock cycles at 100 MHz.

After reset the block holds the memory idle for a long pause. It then runs a burst of dummy cycles and only after that accepts host traffic. From then on a refresh timer asks for an auto-refresh pulse at a fixed interval. The sequencer serves the refresh ahead of any waiting request, but never in the middle of an access. Read results come back on a response strobe that lasts one cycle.

Top module: `psram_ctrl`

## Requirements
- R1: From reset until INIT_CYC (default 10000) cycles have passed, the chip enable stays inactive (mem_ce1_n=1, mem_ce2=0), mem_rfsh_n stays 1 and req_ready stays 0.
- R2: After the pause, exactly DUMMY_N (default 8) dummy cycles run before req_ready first rises. In a dummy cycle chip enable is active while mem_we_n=1 and mem_oe_n=1, and no response is produced.
- R3: The address is on mem_addr one cycle before chip enable falls. It holds the same value until chip enable rises.
- R4: In a write, mem_dq_oe=1 for the whole active window. mem_we_n is low for at least 3 cycles and rises while chip enable is still active. The memory stores req_wdata at req_addr.
- R5: A read asserts mem_oe_n=0 from the third active cycle and samples mem_dq_in on the ninth. rsp_valid rises 10 cycles after the accepting edge and lasts one cycle, carrying the stored byte. A write gives no rsp_valid.
- R6: A read-modify-write (req_rmw=1) runs in one 16-cycle chip-enable window. It returns the old byte on rsp_data 17 cycles after acceptance and leaves req_wdata stored.
- R7: Each chip-enable window lasts at least 9 cycles. Chip enable stays inactive at least 5 cycles between windows.
- R8: Once ready, the block issues an auto-refresh pulse every REF_INTERVAL (default 1500) cycles, even under back-to-back requests. Each pulse holds mem_rfsh_n=0 for 4 cycles, and only while chip enable is inactive.
- R9: mem_dq_oe is never 1 while mem_oe_n is 0.
- R10: req_ready is 1 only when the sequencer is idle with no refresh pending. A request is taken only on req_valid and req_ready together, and a request held during the pause is not served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 100 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_rmw | input | 1 | 1 = read-modify-write (overrides req_write) |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_data | output | 8 | Read data |
| mem_ce1_n | output | 1 | Chip enable, active low |
| mem_ce2 | output | 1 | Chip enable, active high |
| mem_we_n | output | 1 | Read/write strobe, low = write |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_rfsh_n | output | 1 | Refresh pin, active low |
| mem_addr | output | 16 | Memory address |
| mem_dq_out | output | 8 | Data to memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 8 | Data from memory |

## Verification
The embedded assertions check these every cycle:
- bus contention against output enable;
- refresh only while chip enable is inactive;
- address stability during a window;
- minimum window and precharge lengths;
- quiet pins during the pause;
- ready never shown while a refresh is pending;
- no refresh tick lost or left waiting too long.

Only the bench scenarios can show the rest:
- the exact pause and dummy count;
- data actually landing in the memory and coming back;
- the old-then-new order of a read-modify-write;
- response latencies;
- refresh still arriving under a continuous request stream.

// File: rtl/psram_pkg.sv
package psram_pkg;

  typedef enum logic [2:0] {
    ST_INIT, ST_IDLE, ST_SETUP, ST_ACT, ST_PRE, ST_REF
  } seq_state_e;

  typedef enum logic [1:0] {
    OP_DUMMY, OP_RD, OP_WR, OP_RMW
  } mem_op_e;

  // phase counter width and cycle schedule at 10 ns per cycle
  localparam int PH_W        = 5;
  localparam int ACT_PLAIN   = 9;   // 90 ns active window
  localparam int ACT_RMW     = 16;  // 160 ns active window
  localparam int PRE_CYC     = 5;   // 50 ns precharge
  localparam int OE_FIRST    = 2;
  localparam int RD_SAMPLE   = 8;
  localparam int WR_WE_FIRST = 1;
  localparam int WR_WE_LAST  = 7;
  localparam int RMW_DRV     = 10;  // cycle 9 is bus turnaround
  localparam int RMW_WE_FIRST = 11;
  localparam int RMW_WE_LAST  = 14;
  localparam int REF_LOW     = 4;
  localparam int REF_REC     = 12;

  function automatic logic [PH_W-1:0] act_len(input mem_op_e op);
    return (op == OP_RMW) ? PH_W'(ACT_RMW) : PH_W'(ACT_PLAIN);
  endfunction

  function automatic logic reads_data(input mem_op_e op);
    return (op == OP_RD) || (op == OP_RMW);
  endfunction

  function automatic logic oe_window(input mem_op_e op, input logic [PH_W-1:0] ph);
    return reads_data(op) && (ph >= PH_W'(OE_FIRST)) && (ph <= PH_W'(RD_SAMPLE));
  endfunction

  function automatic logic we_window(input mem_op_e op, input logic [PH_W-1:0] ph);
    if (op == OP_WR)  return (ph >= PH_W'(WR_WE_FIRST)) && (ph <= PH_W'(WR_WE_LAST));
    if (op == OP_RMW) return (ph >= PH_W'(RMW_WE_FIRST)) && (ph <= PH_W'(RMW_WE_LAST));
    return 1'b0;
  endfunction

  function automatic logic drive_window(input mem_op_e op, input logic [PH_W-1:0] ph);
    if (op == OP_WR)  return 1'b1;
    if (op == OP_RMW) return ph >= PH_W'(RMW_DRV);
    return 1'b0;
  endfunction

  function automatic logic sample_now(input mem_op_e op, input logic [PH_W-1:0] ph);
    return reads_data(op) && (ph == PH_W'(RD_SAMPLE));
  endfunction

endpackage

// File: rtl/psram_ref_timer.sv
module psram_ref_timer #(
  parameter int INTERVAL = 1500,
  parameter int MAX_WAIT = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ack,
  output logic pending
);
  localparam int CW = $clog2(INTERVAL);
  localparam int WW = $clog2(MAX_WAIT + 2);

  logic [CW-1:0] cnt;
  logic [WW-1:0] wait_cnt;
  logic          tick;

  assign tick = run && (cnt == CW'(INTERVAL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      pending  <= 1'b0;
      wait_cnt <= '0;
    end else begin
      if (run) cnt <= tick ? '0 : cnt + 1'b1;
      if (tick)     pending <= 1'b1;
      else if (ack) pending <= 1'b0;
      if (pending && !ack && wait_cnt != WW'(MAX_WAIT + 1)) wait_cnt <= wait_cnt + 1'b1;
      else if (!pending || ack) wait_cnt <= '0;
    end
  end

  // R8
  no_refresh_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (!pending || ack));
  // R8
  refresh_wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> (wait_cnt < WW'(MAX_WAIT)));
endmodule

// File: rtl/psram_seq.sv
module psram_seq
  import psram_pkg::*;
#(
  parameter int INIT_CYC = 10000,
  parameter int DUMMY_N  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic        req_rmw,
  input  logic [15:0] req_addr,
  input  logic [7:0]  req_wdata,
  output logic        rsp_valid,
  output logic [7:0]  rsp_data,
  input  logic        ref_pending,
  output logic        ref_ack,
  output logic        svc_run,
  output logic        mem_ce1_n,
  output logic        mem_ce2,
  output logic        mem_we_n,
  output logic        mem_oe_n,
  output logic        mem_rfsh_n,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_dq_out,
  output logic        mem_dq_oe,
  input  logic [7:0]  mem_dq_in
);
  localparam int IW = $clog2(INIT_CYC);
  localparam int DW = $clog2(DUMMY_N + 1);
  localparam logic [PH_W-1:0] REF_END = PH_W'(REF_LOW + REF_REC - 1);

  seq_state_e     state;
  mem_op_e        op;
  logic [PH_W-1:0] ph;
  logic [IW-1:0]  init_cnt;
  logic [DW-1:0]  dummy_left;
  logic [15:0]    addr_q;
  logic [7:0]     wdata_q;
  logic           ce_act;
  logic           act_last;

  assign ce_act    = (state == ST_ACT);
  assign act_last  = ce_act && (ph == act_len(op) - 1'b1);
  assign req_ready = (state == ST_IDLE) && !ref_pending;
  assign ref_ack   = (state == ST_IDLE) && ref_pending;
  assign svc_run   = (state != ST_INIT) && (dummy_left == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_INIT;
      op         <= OP_DUMMY;
      ph         <= '0;
      init_cnt   <= '0;
      dummy_left <= DW'(DUMMY_N);
      addr_q     <= '0;
      wdata_q    <= '0;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        ST_INIT: begin
          if (init_cnt == IW'(INIT_CYC - 1)) begin
            state <= ST_ACT;
            ph    <= '0;
          end else init_cnt <= init_cnt + 1'b1;
        end
        ST_IDLE: begin
          if (ref_pending) begin
            state <= ST_REF;
            ph    <= '0;
          end else if (req_valid) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            op      <= req_rmw ? OP_RMW : (req_write ? OP_WR : OP_RD);
            state   <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          state <= ST_ACT;
          ph    <= '0;
        end
        ST_ACT: begin
          if (sample_now(op, ph)) rsp_data <= mem_dq_in;
          if (act_last) begin
            state <= ST_PRE;
            ph    <= '0;
            if (reads_data(op)) rsp_valid <= 1'b1;
            if (op == OP_DUMMY) dummy_left <= dummy_left - 1'b1;
          end else ph <= ph + 1'b1;
        end
        ST_PRE: begin
          if (ph == PH_W'(PRE_CYC - 1)) begin
            state <= (op == OP_DUMMY && dummy_left != '0) ? ST_ACT : ST_IDLE;
            ph    <= '0;
          end else ph <= ph + 1'b1;
        end
        ST_REF: begin
          if (ph == REF_END) begin
            state <= ST_IDLE;
            ph    <= '0;
          end else ph <= ph + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_ce1_n  = !ce_act;
  assign mem_ce2    = ce_act;
  assign mem_oe_n   = !(ce_act && oe_window(op, ph));
  assign mem_we_n   = !(ce_act && we_window(op, ph));
  assign mem_dq_oe  = ce_act && drive_window(op, ph);
  assign mem_rfsh_n = !((state == ST_REF) && (ph < PH_W'(REF_LOW)));
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;

  // window-length observers for the assertions below
  logic [PH_W-1:0] low_run, high_run;
  logic            seen_window;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run     <= '0;
      high_run    <= '0;
      seen_window <= 1'b0;
    end else begin
      low_run  <= mem_ce1_n ? '0 : (low_run == '1 ? low_run : low_run + 1'b1);
      high_run <= !mem_ce1_n ? '0 : (high_run == '1 ? high_run : high_run + 1'b1);
      if (!mem_ce1_n) seen_window <= 1'b1;
    end
  end

  // R9
  bus_vs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);
  // R8
  refresh_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rfsh_n |-> (mem_ce1_n && !mem_ce2));
  // R1
  init_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_INIT) |-> (mem_ce1_n && mem_rfsh_n && !req_ready));
  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce1_n && $past(!mem_ce1_n)) |-> $stable(mem_addr));
  // R7
  ce_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce1_n) |-> (low_run >= PH_W'(ACT_PLAIN)));
  // R7
  ce_precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_ce1_n) && seen_window) |-> (high_run >= PH_W'(PRE_CYC)));
  // R10
  ready_vs_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !ref_pending);
endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl #(
  parameter int INIT_CYC     = 10000,
  parameter int DUMMY_N      = 8,
  parameter int REF_INTERVAL = 1500,
  parameter int REF_MAX_WAIT = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic        req_rmw,
  input  logic [15:0] req_addr,
  input  logic [7:0]  req_wdata,
  output logic        rsp_valid,
  output logic [7:0]  rsp_data,
  output logic        mem_ce1_n,
  output logic        mem_ce2,
  output logic        mem_we_n,
  output logic        mem_oe_n,
  output logic        mem_rfsh_n,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_dq_out,
  output logic        mem_dq_oe,
  input  logic [7:0]  mem_dq_in
);
  logic ref_pending, ref_ack, svc_run;

  psram_ref_timer #(.INTERVAL(REF_INTERVAL), .MAX_WAIT(REF_MAX_WAIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(svc_run), .ack(ref_ack), .pending(ref_pending)
  );

  psram_seq #(.INIT_CYC(INIT_CYC), .DUMMY_N(DUMMY_N)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_rmw(req_rmw), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .ref_pending(ref_pending), .ref_ack(ref_ack), .svc_run(svc_run),
    .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_rfsh_n(mem_rfsh_n), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );
endmodule

// File: tb/psram_ctrl_bench.sv
module psram_ctrl_bench;
  localparam int INIT_CYC = 10000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, req_valid, req_ready, req_write, req_rmw, rsp_valid;
  logic [15:0] req_addr, mem_addr;
  logic [7:0]  req_wdata, rsp_data, mem_dq_out, mem_dq_in;
  logic        mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_rfsh_n, mem_dq_oe;

  psram_ctrl u_psram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_rmw(req_rmw), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_rfsh_n(mem_rfsh_n), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model
  logic [7:0]  mem [logic [15:0]];
  logic [15:0] lat_addr = '0;
  int          ce_age = 0;
  int          viol_wdata = 0;

  function automatic logic [7:0] peek(input logic [15:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  always @(negedge mem_ce1_n) lat_addr = mem_addr;
  always @(posedge mem_we_n) if (mem_ce1_n === 1'b0) begin
    if (!mem_dq_oe) viol_wdata++;
    mem[lat_addr] = mem_dq_out;
  end
  always @(posedge clk) ce_age <= mem_ce1_n ? 0 : ce_age + 1;
  assign mem_dq_in = (!mem_ce1_n && !mem_oe_n && mem_we_n && ce_age >= 8) ? peek(lat_addr) : 8'hEE;

  // pin monitors, sampled at the falling clock edge
  int cyc = 0, first_fall = -1, ce_falls = 0, rf_falls = 0, we_falls = 0, rsp_cnt = 0;
  int ce_lo = 0, ce_hi = 0, we_lo = 0, rf_lo = 0;
  int viol_ce = 0, viol_pre = 0, viol_we = 0, viol_bus = 0, viol_ref = 0, viol_addr = 0, viol_rfw = 0;
  bit prev_ce = 1, prev_we = 1, prev_rf = 1, had_low = 0;

  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (!mem_ce1_n) begin
      if (prev_ce) begin
        ce_falls++;
        if (first_fall < 0) first_fall = cyc;
        if (had_low && ce_hi < 5) viol_pre++;
        had_low = 1;
      end
      if (mem_addr != lat_addr || !mem_ce2) viol_addr++;
      ce_lo++; ce_hi = 0;
    end else begin
      if (!prev_ce && ce_lo < 9) viol_ce++;
      ce_lo = 0; ce_hi++;
    end
    if (!mem_we_n) begin
      if (prev_we) we_falls++;
      we_lo++;
    end else begin
      if (!prev_we && we_lo < 3) viol_we++;
      we_lo = 0;
    end
    if (!mem_rfsh_n) begin
      if (prev_rf) rf_falls++;
      rf_lo++;
    end else begin
      if (!prev_rf && rf_lo != 4) viol_rfw++;
      rf_lo = 0;
    end
    if (mem_dq_oe && !mem_oe_n) viol_bus++;
    if (!mem_rfsh_n && !mem_ce1_n) viol_ref++;
    if (rsp_valid) rsp_cnt++;
    prev_ce = mem_ce1_n; prev_we = mem_we_n; prev_rf = mem_rfsh_n;
  end

  task automatic host(input bit wr, input bit rmw, input logic [15:0] a,
                      input logic [7:0] d, output logic [7:0] q, output int lat);
    int n = 0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_rmw = rmw; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    q = 8'h00; lat = 0;
    if (!wr || rmw) begin
      while (!rsp_valid && n < 100) begin @(negedge clk); n++; end
      q = rsp_data; lat = n;
      @(negedge clk);
      check(!rsp_valid, "R5 rsp pulse width", rsp_valid, 0);
    end
  endtask

  task automatic t_reset_and_init();
    int t0;
    rst_n = 0; req_valid = 0; req_write = 0; req_rmw = 0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    check(mem_ce1_n && !mem_ce2 && mem_rfsh_n && !req_ready && !rsp_valid,
          "R1 reset state", {mem_ce1_n, mem_ce2, mem_rfsh_n, req_ready}, 4'b1010);
    rst_n = 1;
    // R10: a read request held during the pause must not be served
    req_valid = 1; req_write = 0; req_addr = 16'h0042;
    repeat (INIT_CYC / 2) @(negedge clk);
    check(mem_ce1_n && mem_rfsh_n && !req_ready, "R1 quiet mid-pause",
          {mem_ce1_n, mem_rfsh_n, req_ready}, 3'b110);
    while (first_fall < 0) @(negedge clk);
    req_valid = 0;
    check(first_fall >= INIT_CYC, "R1 pause length", first_fall, INIT_CYC);
    t0 = cyc;
    while (!req_ready && cyc - t0 < 1000) @(negedge clk);
    check(ce_falls == 8, "R2 dummy count", ce_falls, 8);
    check(we_falls == 0 && rsp_cnt == 0, "R2 R10 dummies silent", we_falls + rsp_cnt, 0);
  endtask

  task automatic t_write_read(input logic [15:0] a, input logic [7:0] d);
    logic [7:0] q; int lat; int r0;
    r0 = rsp_cnt;
    host(1, 0, a, d, q, lat);
    repeat (30) @(negedge clk);
    check(rsp_cnt == r0, "R5 no rsp on write", rsp_cnt - r0, 0);
    check(peek(a) == d, "R4 stored byte", peek(a), d);
    host(0, 0, a, 8'h00, q, lat);
    check(q == d, "R5 read data", q, d);
    check(lat == 10, "R5 read latency", lat, 10);
  endtask

  task automatic t_rmw(input logic [15:0] a, input logic [7:0] d);
    logic [7:0] q, old; int lat;
    old = peek(a);
    host(1, 1, a, d, q, lat);
    check(q == old, "R6 rmw old data", q, old);
    check(lat == 17, "R6 rmw latency", lat, 17);
    check(peek(a) == d, "R6 rmw new data", peek(a), d);
    host(0, 0, a, 8'h00, q, lat);
    check(q == d, "R6 readback", q, d);
  endtask

  task automatic t_refresh();
    int f0, c0; logic [7:0] q; int lat;
    f0 = rf_falls;
    repeat (15000) @(negedge clk);
    check(rf_falls - f0 >= 9 && rf_falls - f0 <= 11, "R8 idle refresh count", rf_falls - f0, 10);
    f0 = rf_falls; c0 = cyc;
    for (int i = 0; i < 400; i++) host(0, 0, 16'(i), 8'h00, q, lat);
    check(rf_falls - f0 >= (cyc - c0) / 1500 - 1, "R8 refresh under load",
          rf_falls - f0, (cyc - c0) / 1500);
  endtask

  task automatic t_monitors();
    check(viol_ce == 0, "R7 window width", viol_ce, 0);
    check(viol_pre == 0, "R7 precharge", viol_pre, 0);
    check(viol_we == 0 && viol_wdata == 0, "R4 write pulse", viol_we + viol_wdata, 0);
    check(viol_bus == 0, "R9 bus vs oe", viol_bus, 0);
    check(viol_ref == 0 && viol_rfw == 0, "R8 refresh pulse", viol_ref + viol_rfw, 0);
    check(viol_addr == 0, "R3 address hold", viol_addr, 0);
  endtask

  initial begin
    t_reset_and_init();
    t_write_read(16'h0000, 8'h3C);
    t_write_read(16'hFFFF, 8'hC3);
    t_write_read(16'hA5A5, 8'h5A);
    t_write_read(16'h0001, 8'hFF);
    t_rmw(16'h1234, 8'h77);
    t_rmw(16'hA5A5, 8'h81);
    t_refresh();
    t_monitors();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule